// File: doc/BRIEF.md
# Transmit Packet Buffer Loader

This block sits between a host with a byte-wide register bus and a downstream frame sender. It owns an on-chip packet RAM and gives the host two ways to fill it. The streaming port stores each byte at a running head pointer. It moves the tail pointer onto that byte and then steps the head forward. The random-access port stores each byte at an address register that the host sets and steps itself. The tail pointer, which marks the final frame byte, can also be written directly.

To send a frame, the host rewinds the head pointer to zero and checks that the tail is long enough. It then writes the go bit. The block raises a request to the sender and holds the busy flag until the sender reports completion. Completion is either a success or an abort carrying a 5-bit reason code. After an abort in half-duplex operation, the streaming port is locked, and only random-access loading is accepted until a frame completes successfully. While a frame is pending or in flight, the block freezes all host-writable state so the sender sees a stable buffer.

Register select codes (`reg_addr`): 0 head low, 1 head high, 2 tail low, 3 tail high, 4 stream data, 5 random address low, 6 random address high, 7 random data, 8 control (bit 0 = go), 9 busy, 10 success status, 11 abort status. Pointers hold log2(DEPTH) bits, and the bits above that read as zero.

Top module: `txb_loader`

## Requirements
- R1: After synchronous reset, the head, tail and random address all read 0x00, and go, busy, both status registers and `snd_req` are all 0.
- R2: A stream-data write (select 4) stores the byte at the head address, sets the tail to that head address, and advances the head by one.
- R3: The head advances modulo DEPTH, so a stream write at address DEPTH-1 leaves the head at 0 and the tail at DEPTH-1.
- R4: Host writes to the pointer byte registers (selects 0,1,2,3,5,6) read back, and the high-byte bits at or above log2(DEPTH)-8 read as zero.
- R5: A random-data write (select 7) stores the byte at the random address and leaves the random address, the head and the tail unchanged.
- R6: Writing 1 to control bit 0 while idle, with the tail at least 0x0040, makes control read 0x01 for one cycle. On the next cycle, go self-clears, busy reads 0x01, `snd_req` is 1, and `snd_end` equals the tail.
- R7: A go write is refused when the tail is below 0x0040. Go, busy and `snd_req` stay 0.
- R8: While go is pending or busy is set, every host write has no effect: the pointers, the RAM and the control bit are unchanged.
- R9: A `snd_done` pulse with `snd_ok`=1 while busy clears busy on the next cycle, sets success status to 0x80, clears abort status to 0x00, and releases the stream lock.
- R10: A `snd_done` pulse with `snd_ok`=0 clears busy, sets success status to 0x00, and sets abort status to the code in bits 7:3. When `half_duplex` is 1, later stream writes store nothing and move no pointer, while random-access writes still work. When `half_duplex` is 0, there is no lock.
- R11: `snd_rd_data` returns the RAM byte at `snd_rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| half_duplex | input | 1 | Half-duplex operation, enables the abort lock |
| snd_req | output | 1 | Frame send request, high while busy |
| snd_end | output | 16 | Tail pointer given to the sender |
| snd_rd_addr | input | log2(DEPTH) | Sender RAM read address |
| snd_rd_data | output | 8 | Sender RAM read data, one cycle latency |
| snd_done | input | 1 | Sender completion pulse |
| snd_ok | input | 1 | Completion was a success |
| snd_abort_code | input | 5 | Abort reason, valid with snd_done when snd_ok is 0 |

## Verification
The hardest state to reach is the half-duplex stream lock. Reaching it needs a complete launch with a long enough tail, then an aborted completion, before the lock can be observed. Releasing it needs a second launch that completes successfully. The stimulus builds this chain with directed register writes and hand-driven sender completion pulses. After each stage it probes the buffer through the sender read port, and it confirms that random-access writes still land while stream writes do not. The wrap of the head at the top of the buffer and the one-cycle pending window of the go bit are also reached only by placing pointers directly and sampling the cycle between the go write and busy.

// File: rtl/txb_pkg.sv
package txb_pkg;

    typedef enum logic [3:0] {
        RG_HEAD_LO  = 4'd0,
        RG_HEAD_HI  = 4'd1,
        RG_TAIL_LO  = 4'd2,
        RG_TAIL_HI  = 4'd3,
        RG_STREAM   = 4'd4,
        RG_RA_LO    = 4'd5,
        RG_RA_HI    = 4'd6,
        RG_RA_DATA  = 4'd7,
        RG_CTRL     = 4'd8,
        RG_BUSY     = 4'd9,
        RG_STAT_OK  = 4'd10,
        RG_STAT_ABT = 4'd11
    } reg_sel_e;

    typedef struct packed {
        logic        en;
        logic [15:0] addr;
        logic [7:0]  data;
    } ram_wr_t;

    typedef struct packed {
        logic       ok;
        logic [4:0] code;
    } tx_status_t;

    localparam logic [15:0] MIN_TAIL_DEFAULT = 16'h0040;

    function automatic logic [15:0] put_byte(input logic [15:0] v,
                                             input logic hi,
                                             input logic [7:0] b);
        logic [15:0] r;
        r = v;
        if (hi) r[15:8] = b;
        else    r[7:0]  = b;
        return r;
    endfunction

    function automatic logic [7:0] pick_byte(input logic [15:0] v,
                                             input logic hi);
        return hi ? v[15:8] : v[7:0];
    endfunction

endpackage

// File: rtl/txb_ram.sv
module txb_ram
    import txb_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  ram_wr_t       wr,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];
    logic [AW-1:0] wr_a;

    assign wr_a = AW'(wr.addr);

    always_ff @(posedge clk) begin
        if (wr.en) mem[wr_a] <= wr.data;
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/txb_ptr_regs.sv
module txb_ptr_regs
    import txb_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [7:0]    wdata,
    input  logic          blocked,
    input  logic          stream_lock,
    output logic [AW-1:0] head,
    output logic [AW-1:0] tail,
    output logic [AW-1:0] ra_addr,
    output ram_wr_t       ram_wr
);
    logic wr_ok;
    logic strm_ok;
    logic ra_ok;

    assign wr_ok   = wr_en && !blocked;
    assign strm_ok = wr_ok && (sel == RG_STREAM) && !stream_lock;
    assign ra_ok   = wr_ok && (sel == RG_RA_DATA);

    always_comb begin
        ram_wr = '0;
        if (strm_ok) begin
            ram_wr.en   = 1'b1;
            ram_wr.addr = 16'(head);
            ram_wr.data = wdata;
        end else if (ra_ok) begin
            ram_wr.en   = 1'b1;
            ram_wr.addr = 16'(ra_addr);
            ram_wr.data = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head    <= '0;
            tail    <= '0;
            ra_addr <= '0;
        end else if (wr_ok) begin
            unique case (sel)
                RG_HEAD_LO: head    <= AW'(put_byte(16'(head), 1'b0, wdata));
                RG_HEAD_HI: head    <= AW'(put_byte(16'(head), 1'b1, wdata));
                RG_TAIL_LO: tail    <= AW'(put_byte(16'(tail), 1'b0, wdata));
                RG_TAIL_HI: tail    <= AW'(put_byte(16'(tail), 1'b1, wdata));
                RG_RA_LO:   ra_addr <= AW'(put_byte(16'(ra_addr), 1'b0, wdata));
                RG_RA_HI:   ra_addr <= AW'(put_byte(16'(ra_addr), 1'b1, wdata));
                RG_STREAM: begin
                    if (!stream_lock) begin
                        tail <= head;
                        head <= head + AW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assert_head_step_R2: assert property (@(posedge clk) disable iff (rst)
        strm_ok |=> head == AW'($past(head) + AW'(1)));

    assert_tail_follow_R2: assert property (@(posedge clk) disable iff (rst)
        strm_ok |=> tail == $past(head));

    assert_frozen_busy_R8: assert property (@(posedge clk) disable iff (rst)
        blocked |=> $stable(head) && $stable(tail) && $stable(ra_addr));

    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (stream_lock && wr_en && sel == RG_STREAM) |=> $stable(head) && $stable(tail));

    assert_ra_addr_kept_R5: assert property (@(posedge clk) disable iff (rst)
        ra_ok |=> $stable(ra_addr) && $stable(head));
endmodule

// File: rtl/txb_launch.sv
module txb_launch
    import txb_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter logic [15:0] MIN_TAIL = MIN_TAIL_DEFAULT,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_wr,
    input  logic [AW-1:0] tail,
    input  logic          half_duplex,
    input  logic          snd_done,
    input  logic          snd_ok,
    input  logic [4:0]    snd_abort_code,
    output logic          go_q,
    output logic          busy,
    output logic          blocked,
    output logic          stream_lock,
    output tx_status_t    status
);
    logic tail_long;
    logic done_acc;

    assign tail_long = 16'(tail) >= MIN_TAIL;
    assign blocked   = busy || go_q;
    assign done_acc  = busy && snd_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q        <= 1'b0;
            busy        <= 1'b0;
            stream_lock <= 1'b0;
            status      <= '0;
        end else begin
            if (go_q) begin
                go_q <= 1'b0;
                busy <= 1'b1;
            end else if (go_wr && !busy && tail_long) begin
                go_q <= 1'b1;
            end
            if (done_acc) begin
                busy <= 1'b0;
                if (snd_ok) begin
                    status.ok   <= 1'b1;
                    status.code <= '0;
                    stream_lock <= 1'b0;
                end else begin
                    status.ok   <= 1'b0;
                    status.code <= snd_abort_code;
                    stream_lock <= half_duplex;
                end
            end
        end
    end

    assert_go_to_busy_R6: assert property (@(posedge clk) disable iff (rst)
        go_q |=> busy && !go_q);

    assert_short_refused_R7: assert property (@(posedge clk) disable iff (rst)
        (go_wr && !blocked && !tail_long) |=> !go_q && !busy);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done_acc |=> !busy);

    assert_ok_unlocks_R9: assert property (@(posedge clk) disable iff (rst)
        (done_acc && snd_ok) |=> !stream_lock && status.ok);

    assert_phase_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({go_q, busy}));
endmodule

// File: rtl/txb_loader.sv
module txb_loader
    import txb_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter logic [15:0] MIN_TAIL = MIN_TAIL_DEFAULT,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          half_duplex,
    output logic          snd_req,
    output logic [15:0]   snd_end,
    input  logic [AW-1:0] snd_rd_addr,
    output logic [7:0]    snd_rd_data,
    input  logic          snd_done,
    input  logic          snd_ok,
    input  logic [4:0]    snd_abort_code
);
    reg_sel_e      sel;
    logic [AW-1:0] head, tail, ra_addr;
    ram_wr_t       ram_wr;
    logic          go_q, busy, blocked, stream_lock, go_wr;
    tx_status_t    status;

    assign sel   = reg_sel_e'(reg_addr);
    assign go_wr = reg_wr && (sel == RG_CTRL) && reg_wdata[0];

    txb_ptr_regs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(sel), .wdata(reg_wdata),
        .blocked(blocked), .stream_lock(stream_lock),
        .head(head), .tail(tail), .ra_addr(ra_addr), .ram_wr(ram_wr)
    );

    txb_launch #(.DEPTH(DEPTH), .MIN_TAIL(MIN_TAIL)) u_launch (
        .clk(clk), .rst(rst), .go_wr(go_wr), .tail(tail),
        .half_duplex(half_duplex), .snd_done(snd_done), .snd_ok(snd_ok),
        .snd_abort_code(snd_abort_code), .go_q(go_q), .busy(busy),
        .blocked(blocked), .stream_lock(stream_lock), .status(status)
    );

    txb_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk), .wr(ram_wr), .rd_addr(snd_rd_addr), .rd_data(snd_rd_data)
    );

    assign snd_req = busy;
    assign snd_end = 16'(tail);

    always_comb begin
        unique case (sel)
            RG_HEAD_LO:  reg_rdata = pick_byte(16'(head), 1'b0);
            RG_HEAD_HI:  reg_rdata = pick_byte(16'(head), 1'b1);
            RG_TAIL_LO:  reg_rdata = pick_byte(16'(tail), 1'b0);
            RG_TAIL_HI:  reg_rdata = pick_byte(16'(tail), 1'b1);
            RG_RA_LO:    reg_rdata = pick_byte(16'(ra_addr), 1'b0);
            RG_RA_HI:    reg_rdata = pick_byte(16'(ra_addr), 1'b1);
            RG_CTRL:     reg_rdata = {7'b0, go_q};
            RG_BUSY:     reg_rdata = {7'b0, busy};
            RG_STAT_OK:  reg_rdata = {status.ok, 7'b0};
            RG_STAT_ABT: reg_rdata = {status.code, 3'b0};
            default:     reg_rdata = 8'h00;
        endcase
    end

    assert_req_tracks_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(snd_req) |-> $past(go_q));
endmodule

// File: tb/txb_loader_test.sv
module txb_loader_test;
    localparam int DEPTH = 2048;
    localparam int AW = $clog2(DEPTH);

    logic clk = 0, rst = 1;
    logic reg_wr = 0;
    logic [3:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic half_duplex = 0;
    logic snd_req;
    logic [15:0] snd_end;
    logic [AW-1:0] snd_rd_addr = 0;
    logic [7:0] snd_rd_data;
    logic snd_done = 0, snd_ok = 0;
    logic [4:0] snd_abort_code = 0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    txb_loader #(.DEPTH(DEPTH)) uut (.*);

    // vector: [20] read-check, [19:16] select, [15:8] write data, [7:0] expected
    localparam int NV = 22;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'd0, 8'h34, 8'h00}, {1'b0, 4'd1, 8'h12, 8'h00},
        {1'b1, 4'd0, 8'h00, 8'h34}, {1'b1, 4'd1, 8'h00, 8'h02},
        {1'b0, 4'd2, 8'hAB, 8'h00}, {1'b0, 4'd3, 8'hFF, 8'h00},
        {1'b1, 4'd2, 8'h00, 8'hAB}, {1'b1, 4'd3, 8'h00, 8'h07},
        {1'b0, 4'd5, 8'h10, 8'h00}, {1'b0, 4'd6, 8'h00, 8'h00},
        {1'b1, 4'd5, 8'h00, 8'h10}, {1'b0, 4'd0, 8'h00, 8'h00},
        {1'b0, 4'd1, 8'h00, 8'h00}, {1'b0, 4'd4, 8'h5A, 8'h00},
        {1'b1, 4'd2, 8'h00, 8'h00}, {1'b1, 4'd0, 8'h00, 8'h01},
        {1'b0, 4'd4, 8'h6B, 8'h00}, {1'b1, 4'd2, 8'h00, 8'h01},
        {1'b1, 4'd0, 8'h00, 8'h02}, {1'b0, 4'd7, 8'h77, 8'h00},
        {1'b1, 4'd5, 8'h00, 8'h10}, {1'b1, 4'd0, 8'h00, 8'h02}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, 16'(reg_rdata), 16'(exp));
    endtask

    task automatic ram(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        snd_rd_addr = a;
        @(negedge clk);
        chk(req, 16'(snd_rd_data), 16'(exp));
    endtask

    task automatic finish_sender(input logic ok, input logic [4:0] code);
        @(negedge clk);
        snd_done = 1; snd_ok = ok; snd_abort_code = code;
        @(negedge clk);
        snd_done = 0; snd_ok = 0; snd_abort_code = 0;
    endtask

    task automatic launch();
        wr(4'd8, 8'h01);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        rd("R1", 4'd0, 8'h00); rd("R1", 4'd2, 8'h00); rd("R1", 4'd5, 8'h00);
        rd("R1", 4'd8, 8'h00); rd("R1", 4'd9, 8'h00);
        rd("R1", 4'd10, 8'h00); rd("R1", 4'd11, 8'h00);
        chk("R1", 16'(snd_req), 16'd0);

        // table walk: R4 pointer bytes, R2 streaming, R5 random access
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) rd("R2_R4_R5 table", VEC[i][19:16], VEC[i][7:0]);
            else wr(VEC[i][19:16], VEC[i][15:8]);
        end

        // R11 sender read port, contents from R2 and R5
        ram("R11 R2", 11'h000, 8'h5A);
        ram("R11 R2", 11'h001, 8'h6B);
        ram("R11 R5", 11'h010, 8'h77);

        // R3 wrap at the top of the buffer
        wr(4'd0, 8'hFF); wr(4'd1, 8'h07);
        wr(4'd4, 8'h99);
        rd("R3", 4'd0, 8'h00); rd("R3", 4'd1, 8'h00);
        rd("R3", 4'd2, 8'hFF); rd("R3", 4'd3, 8'h07);
        ram("R3", 11'h7FF, 8'h99);

        // R7 short tail refused
        wr(4'd2, 8'h3F); wr(4'd3, 8'h00);
        wr(4'd8, 8'h01);
        rd("R7", 4'd8, 8'h00);
        @(negedge clk);
        rd("R7", 4'd9, 8'h00);
        chk("R7", 16'(snd_req), 16'd0);

        // R6 launch timing
        wr(4'd2, 8'h40);
        wr(4'd8, 8'h01);
        rd("R6", 4'd8, 8'h01);
        chk("R6", 16'(snd_req), 16'd0);
        @(negedge clk);
        rd("R6", 4'd8, 8'h00);
        rd("R6", 4'd9, 8'h01);
        chk("R6", 16'(snd_req), 16'd1);
        chk("R6", snd_end, 16'h0040);

        // R8 writes ignored while busy
        wr(4'd0, 8'h22);
        rd("R8", 4'd0, 8'h00);
        wr(4'd4, 8'hEE);
        ram("R8", 11'h000, 8'h5A);
        wr(4'd2, 8'h55);
        rd("R8", 4'd2, 8'h40);
        chk("R8", 16'(snd_req), 16'd1);

        // R9 successful completion
        finish_sender(1'b1, 5'd0);
        rd("R9", 4'd9, 8'h00);
        rd("R9", 4'd10, 8'h80);
        rd("R9", 4'd11, 8'h00);
        chk("R9", 16'(snd_req), 16'd0);

        // R10 half-duplex abort locks the streaming port
        half_duplex = 1;
        launch();
        finish_sender(1'b0, 5'h13);
        rd("R10", 4'd9, 8'h00);
        rd("R10", 4'd10, 8'h00);
        rd("R10", 4'd11, 8'h98);
        wr(4'd4, 8'hEE);
        rd("R10", 4'd0, 8'h00);
        rd("R10", 4'd2, 8'h40);
        ram("R10", 11'h000, 8'h5A);
        wr(4'd7, 8'h44);
        ram("R10", 11'h010, 8'h44);

        // R9 success releases the lock
        launch();
        finish_sender(1'b1, 5'd0);
        wr(4'd4, 8'hEE);
        rd("R9", 4'd0, 8'h01);
        rd("R9", 4'd2, 8'h00);
        ram("R9", 11'h000, 8'hEE);

        // R10 full-duplex abort does not lock
        half_duplex = 0;
        wr(4'd2, 8'h40);
        launch();
        finish_sender(1'b0, 5'h01);
        rd("R10", 4'd11, 8'h08);
        wr(4'd4, 8'h3C);
        rd("R10", 4'd0, 8'h02);
        rd("R10", 4'd2, 8'h01);
        ram("R10", 11'h001, 8'h3C);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule